// File: doc/BRIEF.md
# Processor Timer Control and Status Registers

This block keeps the two software-visible registers of a processor timer unit. The control register carries the period selects, the interrupt enables, the watchdog reset control and the auto-reload enable. The status register records events raised by the decrementer, the fixed-interval timer and the watchdog. Software writes the control register as a whole and clears status bits by writing ones. The three interrupt lines are registered and each is the AND of a status bit and its enable.

Neighbouring timer blocks take their configuration from decoded outputs. These outputs are the raw period and reset-control fields, the auto-reload enable, and a 6-bit tap index that names the time-base bit whose rising edge ends a period. A one-cycle retarget pulse follows every control write so that the interval timers can reload their target bit. The watchdog state machine sets its own status bits through dedicated pulses and reads them back. A resume-clear pulse clears the watchdog state after a halt, so that a stale expiry does not fire when execution resumes.

Top module: `tmr_csr_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0 and all three interrupt outputs are low.
- R2: A control write replaces all 32 bits, and the new value reads back on the cycle after the write edge.
- R3: `retarget_o` is high for exactly the one cycle after each control write edge and is low otherwise.
- R4: The control fields are decoded as follows. Watchdog period is bits 31:30 and watchdog reset control is bits 29:28. Fixed-interval period is bits 25:24 and auto-reload is bit 22. Interrupt enables are watchdog bit 27, decrementer bit 26 and fixed-interval bit 23.
- R5: With EXT_EN=1 each tap is 63 minus the 6-bit value {extension, period}. The watchdog extension is bits 20:17 and the fixed-interval extension is bits 16:13. With EXT_EN=0 the tap comes from a 4-entry parameter table indexed by the period field.
- R6: Status bits are enable-next-watchdog 31, watchdog interrupt 30, watchdog reset status 29:28, decrementer 27 and fixed-interval 26. Bits 25:0 always read 0. `dec_set_i`, `fit_set_i`, `wdt_int_set_i` and `wdt_next_set_i` set their bits, and `wdt_rst_set_i` loads `wdt_rst_val_i` into bits 29:28.
- R7: A status write clears each bit whose write-data bit is 1 and leaves every other bit unchanged.
- R8: A hardware set pulse in the same cycle as a software clear or a resume clear of the same bit leaves the bit set.
- R9: `resume_clr_i` clears status bits 31:28 and does not change bits 27:26.
- R10: Each interrupt output equals its status bit ANDed with its enable bit as they stood one cycle earlier. The outputs update one cycle after the register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tcr_we_i | input | 1 | Control register write strobe |
| tcr_wdata_i | input | 32 | Control register write data |
| tcr_rdata_o | output | 32 | Control register read-back |
| tsr_we_i | input | 1 | Status register write strobe (write one to clear) |
| tsr_wdata_i | input | 32 | Status register clear mask |
| tsr_rdata_o | output | 32 | Status register read-back |
| dec_set_i | input | 1 | Decrementer event pulse |
| fit_set_i | input | 1 | Fixed-interval event pulse |
| wdt_int_set_i | input | 1 | Watchdog interrupt status set pulse |
| wdt_next_set_i | input | 1 | Enable-next-watchdog set pulse |
| wdt_rst_set_i | input | 1 | Watchdog reset status load pulse |
| wdt_rst_val_i | input | 2 | Value loaded into watchdog reset status |
| resume_clr_i | input | 1 | Clears watchdog status after a halt |
| irq_dec_o | output | 1 | Decrementer interrupt |
| irq_fit_o | output | 1 | Fixed-interval interrupt |
| irq_wdt_o | output | 1 | Watchdog interrupt |
| wdt_per_o | output | 2 | Watchdog period field |
| wdt_rst_ctl_o | output | 2 | Watchdog reset control field |
| fit_per_o | output | 2 | Fixed-interval period field |
| auto_reload_o | output | 1 | Decrementer auto-reload enable |
| wdt_tap_o | output | 6 | Time-base bit index for the watchdog period |
| fit_tap_o | output | 6 | Time-base bit index for the fixed-interval period |
| retarget_o | output | 1 | One-cycle pulse after a control write |
| wdt_next_en_o | output | 1 | Enable-next-watchdog status bit |
| wdt_int_sts_o | output | 1 | Watchdog interrupt status bit |
| wdt_rst_sts_o | output | 2 | Watchdog reset status field |

## Verification
The hardest cases to reach from the ports are the ones where a hardware set pulse lands in the same cycle as a software clear or a resume clear of the same bit. The bench drives the set inputs and the clearing input on one falling edge, so both take effect on the same rising edge. The one-cycle lag of the interrupts behind the status bits is also easy to miss. The bench therefore samples once right after the status edge and once a cycle later, and the two samples must differ. The watchdog reset status field can only be loaded by its load pulse, so the bench loads it before it checks a resume clear.

// File: rtl/tmr_csr_pkg.sv
package tmr_csr_pkg;
  localparam int REG_W = 32;
  localparam int TAP_W = 6;

  // control field positions, decoded by neighbouring timer blocks
  localparam int CTL_WP_LSB  = 30;
  localparam int CTL_WRC_LSB = 28;
  localparam int CTL_WIE     = 27;
  localparam int CTL_DIE     = 26;
  localparam int CTL_FP_LSB  = 24;
  localparam int CTL_FIE     = 23;
  localparam int CTL_ARE     = 22;
  localparam int CTL_WPX_LSB = 17;
  localparam int CTL_FPX_LSB = 13;

  // status field positions
  localparam int STS_ENW     = 31;
  localparam int STS_WIS     = 30;
  localparam int STS_WRS_LSB = 28;
  localparam int STS_DIS     = 27;
  localparam int STS_FIS     = 26;

  // interrupt source index
  localparam int SRC_FIT = 0;
  localparam int SRC_DEC = 1;
  localparam int SRC_WDT = 2;
  localparam int N_SRC   = 3;

  typedef logic [TAP_W-1:0] tap_t;

  function automatic tap_t ext_tap(input logic [1:0] per, input logic [3:0] ext);
    tap_t v;
    v = {ext, per};
    return tap_t'(6'd63 - v);
  endfunction
endpackage

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
  import tmr_csr_pkg::*;
#(
  parameter bit          EXT_EN      = 1'b1,
  parameter logic [23:0] FIT_TAP_TBL = {6'd21, 6'd17, 6'd13, 6'd9},
  parameter logic [23:0] WDT_TAP_TBL = {6'd33, 6'd29, 6'd25, 6'd21}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [1:0]       wdt_per_o,
  output logic [1:0]       wdt_rst_ctl_o,
  output logic [1:0]       fit_per_o,
  output logic             auto_reload_o,
  output logic [N_SRC-1:0] irq_en_o,
  output tap_t             wdt_tap_o,
  output tap_t             fit_tap_o,
  output logic             retarget_o
);
  logic [REG_W-1:0] ctl_q;
  logic             retarget_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= '0;
      retarget_q <= 1'b0;
    end else begin
      retarget_q <= we_i;
      if (we_i) ctl_q <= wdata_i;
    end
  end

  assign rdata_o       = ctl_q;
  assign retarget_o    = retarget_q;
  assign wdt_per_o     = ctl_q[CTL_WP_LSB +: 2];
  assign wdt_rst_ctl_o = ctl_q[CTL_WRC_LSB +: 2];
  assign fit_per_o     = ctl_q[CTL_FP_LSB +: 2];
  assign auto_reload_o = ctl_q[CTL_ARE];

  always_comb begin
    irq_en_o          = '0;
    irq_en_o[SRC_FIT] = ctl_q[CTL_FIE];
    irq_en_o[SRC_DEC] = ctl_q[CTL_DIE];
    irq_en_o[SRC_WDT] = ctl_q[CTL_WIE];
  end

  generate
    if (EXT_EN) begin : g_ext
      assign wdt_tap_o = ext_tap(wdt_per_o, ctl_q[CTL_WPX_LSB +: 4]);
      assign fit_tap_o = ext_tap(fit_per_o, ctl_q[CTL_FPX_LSB +: 4]);
    end else begin : g_tbl
      assign wdt_tap_o = WDT_TAP_TBL[wdt_per_o*TAP_W +: TAP_W];
      assign fit_tap_o = FIT_TAP_TBL[fit_per_o*TAP_W +: TAP_W];
    end
  endgenerate
endmodule

// File: rtl/tmr_sts_reg.sv
module tmr_sts_reg
  import tmr_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             dec_set_i,
  input  logic             fit_set_i,
  input  logic             wdt_int_set_i,
  input  logic             wdt_next_set_i,
  input  logic             wdt_rst_set_i,
  input  logic [1:0]       wdt_rst_val_i,
  input  logic             resume_clr_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [N_SRC-1:0] sts_o
);
  logic       enw_q, wis_q, dis_q, fis_q;
  logic [1:0] wrs_q;
  logic [REG_W-1:0] clr;

  assign clr = we_i ? wdata_i : '0;

  // set has priority over both software and resume clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enw_q <= 1'b0;
      wis_q <= 1'b0;
      wrs_q <= 2'b00;
      dis_q <= 1'b0;
      fis_q <= 1'b0;
    end else begin
      enw_q <= wdt_next_set_i | (enw_q & ~clr[STS_ENW] & ~resume_clr_i);
      wis_q <= wdt_int_set_i  | (wis_q & ~clr[STS_WIS] & ~resume_clr_i);
      dis_q <= dec_set_i      | (dis_q & ~clr[STS_DIS]);
      fis_q <= fit_set_i      | (fis_q & ~clr[STS_FIS]);
      if (wdt_rst_set_i) wrs_q <= wdt_rst_val_i;
      else if (resume_clr_i) wrs_q <= 2'b00;
      else wrs_q <= wrs_q & ~clr[STS_WRS_LSB +: 2];
    end
  end

  always_comb begin
    rdata_o                    = '0;
    rdata_o[STS_ENW]           = enw_q;
    rdata_o[STS_WIS]           = wis_q;
    rdata_o[STS_WRS_LSB +: 2]  = wrs_q;
    rdata_o[STS_DIS]           = dis_q;
    rdata_o[STS_FIS]           = fis_q;
    sts_o                      = '0;
    sts_o[SRC_FIT]             = fis_q;
    sts_o[SRC_DEC]             = dis_q;
    sts_o[SRC_WDT]             = wis_q;
  end
endmodule

// File: rtl/tmr_irq_gen.sv
module tmr_irq_gen
  import tmr_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] sts_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_SRC-1:0] irq_o
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic irq_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= sts_i[s] & en_i[s];
    end
    assign irq_o[s] = irq_q;
  end
endmodule

// File: rtl/tmr_csr_top.sv
module tmr_csr_top
  import tmr_csr_pkg::*;
#(
  parameter bit          EXT_EN      = 1'b1,
  parameter logic [23:0] FIT_TAP_TBL = {6'd21, 6'd17, 6'd13, 6'd9},
  parameter logic [23:0] WDT_TAP_TBL = {6'd33, 6'd29, 6'd25, 6'd21}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tcr_we_i,
  input  logic [31:0] tcr_wdata_i,
  output logic [31:0] tcr_rdata_o,
  input  logic        tsr_we_i,
  input  logic [31:0] tsr_wdata_i,
  output logic [31:0] tsr_rdata_o,
  input  logic        dec_set_i,
  input  logic        fit_set_i,
  input  logic        wdt_int_set_i,
  input  logic        wdt_next_set_i,
  input  logic        wdt_rst_set_i,
  input  logic [1:0]  wdt_rst_val_i,
  input  logic        resume_clr_i,
  output logic        irq_dec_o,
  output logic        irq_fit_o,
  output logic        irq_wdt_o,
  output logic [1:0]  wdt_per_o,
  output logic [1:0]  wdt_rst_ctl_o,
  output logic [1:0]  fit_per_o,
  output logic        auto_reload_o,
  output logic [5:0]  wdt_tap_o,
  output logic [5:0]  fit_tap_o,
  output logic        retarget_o,
  output logic        wdt_next_en_o,
  output logic        wdt_int_sts_o,
  output logic [1:0]  wdt_rst_sts_o
);
  logic [N_SRC-1:0] irq_en, sts, irq;

  tmr_ctl_reg #(
    .EXT_EN(EXT_EN), .FIT_TAP_TBL(FIT_TAP_TBL), .WDT_TAP_TBL(WDT_TAP_TBL)
  ) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(tcr_we_i), .wdata_i(tcr_wdata_i),
    .rdata_o(tcr_rdata_o), .wdt_per_o(wdt_per_o), .wdt_rst_ctl_o(wdt_rst_ctl_o),
    .fit_per_o(fit_per_o), .auto_reload_o(auto_reload_o), .irq_en_o(irq_en),
    .wdt_tap_o(wdt_tap_o), .fit_tap_o(fit_tap_o), .retarget_o(retarget_o)
  );

  tmr_sts_reg u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(tsr_we_i), .wdata_i(tsr_wdata_i),
    .dec_set_i(dec_set_i), .fit_set_i(fit_set_i), .wdt_int_set_i(wdt_int_set_i),
    .wdt_next_set_i(wdt_next_set_i), .wdt_rst_set_i(wdt_rst_set_i),
    .wdt_rst_val_i(wdt_rst_val_i), .resume_clr_i(resume_clr_i),
    .rdata_o(tsr_rdata_o), .sts_o(sts)
  );

  tmr_irq_gen u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sts_i(sts), .en_i(irq_en), .irq_o(irq)
  );

  assign irq_fit_o     = irq[SRC_FIT];
  assign irq_dec_o     = irq[SRC_DEC];
  assign irq_wdt_o     = irq[SRC_WDT];
  assign wdt_next_en_o = tsr_rdata_o[STS_ENW];
  assign wdt_int_sts_o = tsr_rdata_o[STS_WIS];
  assign wdt_rst_sts_o = tsr_rdata_o[STS_WRS_LSB +: 2];
endmodule

// File: rtl/tmr_csr_chk.sv
module tmr_csr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tcr_we_i,
  input logic [31:0] tcr_wdata_i,
  input logic [31:0] tcr_rdata_o,
  input logic        tsr_we_i,
  input logic [31:0] tsr_wdata_i,
  input logic [31:0] tsr_rdata_o,
  input logic        dec_set_i,
  input logic        fit_set_i,
  input logic        wdt_int_set_i,
  input logic        wdt_next_set_i,
  input logic        wdt_rst_set_i,
  input logic        resume_clr_i,
  input logic        irq_dec_o,
  input logic        irq_fit_o,
  input logic        irq_wdt_o,
  input logic        retarget_o
);
  // R2
  tcr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcr_we_i |=> tcr_rdata_o == $past(tcr_wdata_i));
  // R3
  retarget_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcr_we_i |=> retarget_o);
  // R3
  retarget_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tcr_we_i |=> !retarget_o);
  // R6
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsr_rdata_o[25:0] == 26'd0);
  // R7
  w1c_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsr_we_i && tsr_wdata_i[27] && !dec_set_i) |=> !tsr_rdata_o[27]);
  // R8
  dec_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_set_i |=> tsr_rdata_o[27]);
  // R8
  fit_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fit_set_i |=> tsr_rdata_o[26]);
  // R9
  resume_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_clr_i && !wdt_next_set_i && !wdt_int_set_i && !wdt_rst_set_i)
    |=> tsr_rdata_o[31:28] == 4'd0);
  // R9
  resume_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_clr_i && !tsr_we_i && !dec_set_i && !fit_set_i)
    |=> tsr_rdata_o[27:26] == $past(tsr_rdata_o[27:26]));
  // R10
  irq_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_dec_o == ($past(tsr_rdata_o[27]) && $past(tcr_rdata_o[26])));
  // R10
  irq_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_fit_o == ($past(tsr_rdata_o[26]) && $past(tcr_rdata_o[23])));
  // R10
  irq_wdt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_wdt_o == ($past(tsr_rdata_o[30]) && $past(tcr_rdata_o[27])));
endmodule

bind tmr_csr_top tmr_csr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tcr_we_i(tcr_we_i), .tcr_wdata_i(tcr_wdata_i),
  .tcr_rdata_o(tcr_rdata_o), .tsr_we_i(tsr_we_i), .tsr_wdata_i(tsr_wdata_i),
  .tsr_rdata_o(tsr_rdata_o), .dec_set_i(dec_set_i), .fit_set_i(fit_set_i),
  .wdt_int_set_i(wdt_int_set_i), .wdt_next_set_i(wdt_next_set_i),
  .wdt_rst_set_i(wdt_rst_set_i), .resume_clr_i(resume_clr_i),
  .irq_dec_o(irq_dec_o), .irq_fit_o(irq_fit_o), .irq_wdt_o(irq_wdt_o),
  .retarget_o(retarget_o)
);

// File: tb/tmr_csr_top_tb_top.sv
module tmr_csr_top_tb_top;
  localparam int CLK_P   = 10;
  localparam int WD_MAX  = 20000;
  localparam int N_VEC   = 8;

  // {tcr[31:0], set{wis,dec,fit}, clr[31:0], exp_tsr[31:0], exp_irq{wdt,dec,fit}}
  localparam logic [101:0] VEC [N_VEC] = '{
    {32'h0C80_0000, 3'b111, 32'h0000_0000, 32'h4C00_0000, 3'b111},
    {32'h0400_0000, 3'b111, 32'h0000_0000, 32'h4C00_0000, 3'b010},
    {32'h0C80_0000, 3'b111, 32'h0800_0000, 32'h4400_0000, 3'b101},
    {32'h0800_0000, 3'b100, 32'h0000_0000, 32'h4000_0000, 3'b100},
    {32'h0080_0000, 3'b001, 32'h4000_0000, 32'h0400_0000, 3'b001},
    {32'h0000_0000, 3'b111, 32'h0000_0000, 32'h4C00_0000, 3'b000},
    {32'hFFFF_FFFF, 3'b000, 32'h0000_0000, 32'h0000_0000, 3'b000},
    {32'h0C80_0000, 3'b111, 32'hFFFF_FFFF, 32'h0000_0000, 3'b000}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        tcr_we_i = 1'b0, tsr_we_i = 1'b0;
  logic [31:0] tcr_wdata_i = '0, tsr_wdata_i = '0;
  logic        dec_set_i = 1'b0, fit_set_i = 1'b0, wdt_int_set_i = 1'b0;
  logic        wdt_next_set_i = 1'b0, wdt_rst_set_i = 1'b0, resume_clr_i = 1'b0;
  logic [1:0]  wdt_rst_val_i = 2'b00;
  logic [31:0] tcr_rdata_o, tsr_rdata_o;
  logic        irq_dec_o, irq_fit_o, irq_wdt_o, auto_reload_o, retarget_o;
  logic        wdt_next_en_o, wdt_int_sts_o;
  logic [1:0]  wdt_per_o, wdt_rst_ctl_o, fit_per_o, wdt_rst_sts_o;
  logic [5:0]  wdt_tap_o, fit_tap_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tmr_csr_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tcr_we_i(tcr_we_i), .tcr_wdata_i(tcr_wdata_i),
    .tcr_rdata_o(tcr_rdata_o), .tsr_we_i(tsr_we_i), .tsr_wdata_i(tsr_wdata_i),
    .tsr_rdata_o(tsr_rdata_o), .dec_set_i(dec_set_i), .fit_set_i(fit_set_i),
    .wdt_int_set_i(wdt_int_set_i), .wdt_next_set_i(wdt_next_set_i),
    .wdt_rst_set_i(wdt_rst_set_i), .wdt_rst_val_i(wdt_rst_val_i),
    .resume_clr_i(resume_clr_i), .irq_dec_o(irq_dec_o), .irq_fit_o(irq_fit_o),
    .irq_wdt_o(irq_wdt_o), .wdt_per_o(wdt_per_o), .wdt_rst_ctl_o(wdt_rst_ctl_o),
    .fit_per_o(fit_per_o), .auto_reload_o(auto_reload_o), .wdt_tap_o(wdt_tap_o),
    .fit_tap_o(fit_tap_o), .retarget_o(retarget_o), .wdt_next_en_o(wdt_next_en_o),
    .wdt_int_sts_o(wdt_int_sts_o), .wdt_rst_sts_o(wdt_rst_sts_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIT check %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance one rising edge, return at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    tcr_we_i = 0; tsr_we_i = 0; dec_set_i = 0; fit_set_i = 0; wdt_int_set_i = 0;
    wdt_next_set_i = 0; wdt_rst_set_i = 0; resume_clr_i = 0;
  endtask

  function automatic logic [2:0] irqs();
    return {irq_wdt_o, irq_dec_o, irq_fit_o};
  endfunction

  initial begin
    for (int c = 0; c < WD_MAX; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tcr", tcr_rdata_o, 32'h0);
    check("R1 tsr", tsr_rdata_o, 32'h0);
    check("R1 irq", {29'd0, irqs()}, 32'h0);
    rst_ni = 1'b1;
    step();

    // vector table: R7 R10
    for (int v = 0; v < N_VEC; v++) begin
      tcr_we_i = 1; tcr_wdata_i = VEC[v][101:70];
      {wdt_int_set_i, dec_set_i, fit_set_i} = VEC[v][69:67];
      step();
      idle_inputs();
      tsr_we_i = 1; tsr_wdata_i = VEC[v][66:35];
      step();
      idle_inputs();
      check($sformatf("R7 vec%0d tsr", v), tsr_rdata_o, VEC[v][34:3]);
      step();
      check($sformatf("R10 vec%0d irq", v), {29'd0, irqs()}, {29'd0, VEC[v][2:0]});
      tsr_we_i = 1; tsr_wdata_i = 32'hFFFF_FFFF;
      step();
      idle_inputs();
      step();
    end

    // R2 R3 R4 R5 decode
    tcr_we_i = 1; tcr_wdata_i = 32'h9356_C000;
    step();
    tcr_we_i = 0;
    check("R2 readback", tcr_rdata_o, 32'h9356_C000);
    check("R3 pulse high", {31'd0, retarget_o}, 32'd1);
    check("R4 fields", {23'd0, wdt_per_o, wdt_rst_ctl_o, fit_per_o, auto_reload_o},
          {23'd0, 2'b10, 2'b01, 2'b11, 1'b1});
    check("R5 wdt tap", {26'd0, wdt_tap_o}, 32'd17);
    check("R5 fit tap", {26'd0, fit_tap_o}, 32'd36);
    step();
    check("R3 pulse low", {31'd0, retarget_o}, 32'd0);

    // R10 timing: one cycle lag
    tcr_we_i = 1; tcr_wdata_i = 32'h0400_0000;
    step();
    tcr_we_i = 0; dec_set_i = 1;
    step();
    dec_set_i = 0;
    check("R10 status set, irq lags", {31'd0, tsr_rdata_o[27], irq_dec_o}, 32'b10);
    step();
    check("R10 irq follows", {31'd0, irq_dec_o}, 32'd1);

    // R8 set wins over software clear
    tsr_we_i = 1; tsr_wdata_i = 32'h0C00_0000; dec_set_i = 1;
    step();
    idle_inputs();
    check("R8 set beats clear", tsr_rdata_o, 32'h0800_0000);

    // R6 watchdog set pulses and unused bits
    wdt_next_set_i = 1; wdt_int_set_i = 1; wdt_rst_set_i = 1; wdt_rst_val_i = 2'b11;
    fit_set_i = 1;
    step();
    idle_inputs();
    check("R6 all status", tsr_rdata_o, 32'hFC00_0000);
    check("R6 status outs", {28'd0, wdt_next_en_o, wdt_int_sts_o, wdt_rst_sts_o}, 32'hF);

    // R9 resume clears watchdog bits only
    resume_clr_i = 1;
    step();
    idle_inputs();
    check("R9 resume", tsr_rdata_o, 32'h0C00_0000);

    // R8 set beats resume
    resume_clr_i = 1; wdt_int_set_i = 1;
    step();
    idle_inputs();
    check("R8 set beats resume", tsr_rdata_o, 32'h4C00_0000);

    // R7 partial clear leaves others
    tsr_we_i = 1; tsr_wdata_i = 32'h0400_0000;
    step();
    idle_inputs();
    check("R7 partial clear", tsr_rdata_o, 32'h4800_0000);

    // R1 reset mid-run
    rst_ni = 0;
    step();
    check("R1 reset again", tcr_rdata_o | tsr_rdata_o | {29'd0, irqs()}, 32'h0);
    rst_ni = 1;
    step();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule